// File: doc/BRIEF.md
# Host-Patchable Microcode Sequencer

This block runs long control sequences out of a writable control store instead of a fixed ROM. A program counter addresses a 256-entry store of 16-bit microwords. Every time the engine advances, the addressed word is latched into a pipeline register, and the next address is worked out from that same word. Each word carries a next-address mode, a condition selector, three control outputs and an 8-bit branch target. Up to eight external condition inputs steer branching by choosing between the target and the incremented address, or by replacing the two low bits of the target.

A host drives the block through its own port. The engine comes out of reset halted. While it is halted, the host can patch single store words and preload the program counter, which lets one store hold several sequences that are started by address. The host can also start free running, halt, and single-step one microinstruction at a time. The pipeline register is visible at all times for readback. A store write or preload made while the engine runs is dropped and reported with a one-cycle error pulse.

Top module: `useq_engine`

## Requirements
- R1: During reset and until the first advance, pc_out is 0, pipe_word is 0, ctrl_out is 0, running is 0 and host_err is 0.
- R2: While the engine is halted, a cycle with host_wr_en high stores host_wr_data at host_wr_addr. A later fetch from that address loads exactly that word into pipe_word.
- R3: While running is 1, host_wr_en and host_pc_ld have no effect: the store and the program counter keep following the program. For one cycle after such a request, host_err is 1. At all other times host_err is 0.
- R4: While halted, host_pc_ld sets pc_out to host_pc_val on the next clock and leaves pipe_word unchanged. The first advance after that fetches the word at the new address. ctrl_out changes only when that word is registered.
- R5: While halted, each cycle with host_step high (and host_pc_ld low) performs exactly one advance. When no step, preload or start is requested, pc_out and pipe_word hold their values. A step request while running adds no extra advance.
- R6: A host_start pulse sets running on the next clock, and the engine advances on every clock after that. A host_halt pulse clears running on the next clock and suppresses the advance on that clock. If host_start and host_halt arrive together, the halt wins.
- R7: An advance loads the word at pc_out into pipe_word. Mode bits [15:14]=00 then set pc_out to pc_out+1, and the address wraps from 255 to 0.
- R8: Mode 01 sets the next pc_out to the target field in bits [7:0].
- R9: Mode 10 jumps to the target when cond_in[s] is 1, where s is bits [13:11]. Otherwise it increments.
- R10: Mode 11 sets the next pc_out to {target[7:2], cond_in[(s+1) mod 8], cond_in[s]}.
- R11: pipe_word always shows the pipeline register, and ctrl_out always equals its bits [10:8].
- R12: When host_pc_ld and host_step arrive in the same halted cycle, the preload takes effect and no advance occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Control-store write request |
| host_wr_addr | input | 8 | Control-store write address |
| host_wr_data | input | 16 | Control-store write data |
| host_pc_ld | input | 1 | Program counter preload request |
| host_pc_val | input | 8 | Program counter preload value |
| host_start | input | 1 | Start free running |
| host_halt | input | 1 | Halt the engine |
| host_step | input | 1 | Single-step request while halted |
| cond_in | input | 8 | External branch conditions |
| running | output | 1 | Engine is free running |
| host_err | output | 1 | Pulse: request dropped while running |
| pc_out | output | 8 | Program counter |
| pipe_word | output | 16 | Pipeline register readback |
| ctrl_out | output | 3 | Control outputs of the registered word |

## Verification
On every cycle, the assertions check the following:
- a halted engine holds its state when no request is made;
- a halted preload lands in the counter without disturbing the pipeline;
- a halted step latches the word the store presents;
- a request made while running raises the error pulse;
- halt always wins over start;
- the counter wraps from 255 to 0.

The bench's scenarios are what show the rest. These are the patched contents reaching the pipeline, the branch targets each mode picks under random conditions, and the length of free-run sequences. They also show that writes and preloads issued while running left the store and the counter untouched.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    NA_INC  = 2'b00,
    NA_JMP  = 2'b01,
    NA_CJMP = 2'b10,
    NA_MWAY = 2'b11
  } na_mode_e;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter int COND_N = 8
) (
  input  logic [WORD_W-1:0] word,
  input  logic [ADDR_W-1:0] pc,
  input  logic [COND_N-1:0] cond,
  output logic [ADDR_W-1:0] next_pc
);
  localparam int SEL_W   = $clog2(COND_N);
  localparam int MODE_LO = WORD_W - 2;
  localparam int SEL_LO  = MODE_LO - SEL_W;

  na_mode_e          mode;
  logic [SEL_W-1:0]  sel;
  logic [SEL_W-1:0]  sel_nx;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] pc_inc;

  assign mode   = na_mode_e'(word[WORD_W-1:MODE_LO]);
  assign sel    = word[MODE_LO-1:SEL_LO];
  assign sel_nx = sel + 1'b1;
  assign target = word[ADDR_W-1:0];
  assign pc_inc = pc + 1'b1;

  always_comb begin
    case (mode)
      NA_INC:  next_pc = pc_inc;
      NA_JMP:  next_pc = target;
      NA_CJMP: next_pc = cond[sel] ? target : pc_inc;
      default: next_pc = {target[ADDR_W-1:2], cond[sel_nx], cond[sel]};
    endcase
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic halt_req,
  input  logic step_req,
  input  logic pc_ld_req,
  input  logic wr_req,
  output logic running,
  output logic advance,
  output logic pc_load,
  output logic store_we,
  output logic err
);
  logic running_q, running_d;
  logic err_q, err_d;

  always_comb begin
    running_d = running_q;
    if (halt_req) begin
      running_d = 1'b0;
    end else if (start_req) begin
      running_d = 1'b1;
    end
    err_d = running_q & (wr_req | pc_ld_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      running_q <= running_d;
      err_q     <= err_d;
    end
  end

  assign advance  = running_q ? ~halt_req : (step_req & ~pc_ld_req);
  assign pc_load  = ~running_q & pc_ld_req;
  assign store_we = ~running_q & wr_req;
  assign running  = running_q;
  assign err      = err_q;

  p_halt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> !running_q);

  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && !halt_req) |=> running_q);
endmodule

// File: rtl/useq_engine.sv
module useq_engine #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16,
  parameter int COND_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [WORD_W-1:0] host_wr_data,
  input  logic              host_pc_ld,
  input  logic [ADDR_W-1:0] host_pc_val,
  input  logic              host_start,
  input  logic              host_halt,
  input  logic              host_step,
  input  logic [COND_N-1:0] cond_in,
  output logic              running,
  output logic              host_err,
  output logic [ADDR_W-1:0] pc_out,
  output logic [WORD_W-1:0] pipe_word,
  output logic [WORD_W-ADDR_W-$clog2(COND_N)-3:0] ctrl_out
);
  localparam int SEL_W  = $clog2(COND_N);
  localparam int CTRL_W = WORD_W - ADDR_W - SEL_W - 2;

  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic              advance, pc_load, store_we;
  logic [WORD_W-1:0] rd_word;
  logic [ADDR_W-1:0] next_pc;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [WORD_W-1:0] pipe_q, pipe_d;
  logic              pc_en, pipe_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  useq_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start_req (host_start),
    .halt_req  (host_halt),
    .step_req  (host_step),
    .pc_ld_req (host_pc_ld),
    .wr_req    (host_wr_en),
    .running   (running),
    .advance   (advance),
    .pc_load   (pc_load),
    .store_we  (store_we),
    .err       (host_err)
  );

  useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) store_i (
    .clk   (clk),
    .we    (store_we),
    .waddr (host_wr_addr),
    .wdata (host_wr_data),
    .raddr (pc_q),
    .rdata (rd_word)
  );

  useq_next_addr #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .COND_N(COND_N)) nxt_i (
    .word    (rd_word),
    .pc      (pc_q),
    .cond    (cond_in),
    .next_pc (next_pc)
  );

  always_comb begin
    pc_en   = pc_load | advance;
    pc_d    = pc_load ? host_pc_val : next_pc;
    pipe_en = advance;
    pipe_d  = rd_word;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pc_q   <= '0;
      pipe_q <= '0;
    end else begin
      if (pc_en) begin
        pc_q <= pc_d;
      end
      if (pipe_en) begin
        pipe_q <= pipe_d;
      end
    end
  end

  assign pc_out    = pc_q;
  assign pipe_word = pipe_q;
  assign ctrl_out  = pipe_q[ADDR_W+CTRL_W-1:ADDR_W];

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!running && !host_step && !host_pc_ld && !host_start)
      |=> ($stable(pc_q) && $stable(pipe_q)));

  p_preload_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!running && host_pc_ld) |=> (pc_q == $past(host_pc_val) && $stable(pipe_q)));

  p_step_fetch_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!running && host_step && !host_pc_ld) |=> (pipe_q == $past(rd_word)));

  p_drop_err_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (running && (host_wr_en || host_pc_ld)) |=> host_err);

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (advance && !pc_load && rd_word[WORD_W-1:WORD_W-2] == 2'b00 && pc_q == '1)
      |=> (pc_q == '0));
endmodule

// File: tb/useq_engine_tb_top.sv
module useq_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_en, host_pc_ld, host_start, host_halt, host_step;
  logic [7:0]  host_wr_addr, host_pc_val, cond_in;
  logic [15:0] host_wr_data;
  logic        running, host_err;
  logic [7:0]  pc_out;
  logic [15:0] pipe_word;
  logic [2:0]  ctrl_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] ref_mem [256];
  logic [7:0]  ref_pc;
  logic [15:0] ref_pipe;

  always #5 clk = ~clk;

  useq_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_pc_ld(host_pc_ld), .host_pc_val(host_pc_val),
    .host_start(host_start), .host_halt(host_halt), .host_step(host_step),
    .cond_in(cond_in), .running(running), .host_err(host_err),
    .pc_out(pc_out), .pipe_word(pipe_word), .ctrl_out(ctrl_out)
  );

  function automatic logic [7:0] f_next(logic [15:0] w, logic [7:0] pc, logic [7:0] c);
    logic [2:0] s;
    logic [2:0] s1;
    s  = w[13:11];
    s1 = s + 3'd1;
    case (w[15:14])
      2'b00:   return pc + 8'd1;
      2'b01:   return w[7:0];
      2'b10:   return c[s] ? w[7:0] : pc + 8'd1;
      default: return {w[7:2], c[s1], c[s]};
    endcase
  endfunction

  function automatic void model_adv(logic [7:0] c);
    ref_pipe = ref_mem[ref_pc];
    ref_pc   = f_next(ref_pipe, ref_pc, c);
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk(pc_out == ref_pc, {tag, " pc"}, pc_out, ref_pc);
    chk(pipe_word == ref_pipe, {tag, " pipe R11"}, pipe_word, ref_pipe);
    chk(ctrl_out == ref_pipe[10:8], {tag, " ctrl R11"}, ctrl_out, ref_pipe[10:8]);
  endtask

  task automatic do_write(logic [7:0] a, logic [15:0] d);
    host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
    ref_mem[a] = d;
  endtask

  task automatic do_load(logic [7:0] v);
    host_pc_ld = 1'b1; host_pc_val = v;
    @(negedge clk);
    host_pc_ld = 1'b0;
    ref_pc = v;
  endtask

  task automatic do_step(logic [7:0] c, string tag);
    cond_in = c; host_step = 1'b1;
    @(negedge clk);
    host_step = 1'b0;
    model_adv(c);
    chk_state(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; host_wr_en = 0; host_pc_ld = 0; host_start = 0; host_halt = 0;
    host_step = 0; host_wr_addr = 0; host_pc_val = 0; host_wr_data = 0; cond_in = 0;
    ref_pc = 0; ref_pipe = 0;
    repeat (3) @(negedge clk);
    chk(pc_out == 0 && pipe_word == 0 && running == 0 && host_err == 0,
        "R1 in reset", {pc_out, pipe_word}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_state("R1 after reset");
    chk(running == 0, "R1 halted", running, 0);
    chk(host_err == 0, "R1 err", host_err, 0);

    // Fill store with random program (halted writes, R2)
    for (int i = 0; i < 256; i++) begin
      do_write(i[7:0], 16'($urandom()));
      if (host_err) chk(0, "R3 err on halted write", host_err, 0);
    end
    chk_state("R2 writes leave pc/pipe");

    // R2 patch and fetch
    do_write(8'h10, 16'h0A55);
    do_load(8'h10);
    chk_state("R4 preload keeps pipe");
    do_step(8'h00, "R2 patched fetch");
    chk(pipe_word == 16'h0A55, "R2 word", pipe_word, 16'h0A55);
    chk(ctrl_out == 3'b010, "R4 ctrl after fetch", ctrl_out, 3'b010);

    // R7 wrap
    do_write(8'hFF, {2'b00, 3'd0, 3'b111, 8'h33});
    do_load(8'hFF);
    do_step(8'h00, "R7 wrap");
    chk(pc_out == 8'h00, "R7 wrap to 0", pc_out, 0);

    // R8 jump
    do_write(8'h20, {2'b01, 3'd2, 3'b101, 8'h40});
    do_load(8'h20);
    do_step(8'hFF, "R8 jump");
    chk(pc_out == 8'h40, "R8 target", pc_out, 8'h40);

    // R9 conditional, taken and not taken
    do_write(8'h21, {2'b10, 3'd5, 3'b001, 8'h80});
    do_load(8'h21);
    do_step(8'h20, "R9 taken");
    chk(pc_out == 8'h80, "R9 taken pc", pc_out, 8'h80);
    do_load(8'h21);
    do_step(8'hDF, "R9 not taken");
    chk(pc_out == 8'h22, "R9 not taken pc", pc_out, 8'h22);

    // R10 multiway, sel 7 wraps to 0 for high bit
    do_write(8'h22, {2'b11, 3'd7, 3'b110, 8'hC7});
    do_load(8'h22);
    do_step(8'h81, "R10 multiway");
    chk(pc_out == 8'hC7, "R10 pc 11", pc_out, 8'hC7);
    do_load(8'h22);
    do_step(8'h01, "R10 multiway b");
    chk(pc_out == 8'hC6, "R10 pc 10", pc_out, 8'hC6);

    // R12 preload and step together
    host_pc_ld = 1'b1; host_pc_val = 8'h5A; host_step = 1'b1;
    @(negedge clk);
    host_pc_ld = 1'b0; host_step = 1'b0; ref_pc = 8'h5A;
    chk_state("R12 preload wins");

    // R5 hold with no request
    repeat (3) @(negedge clk);
    chk_state("R5 idle hold");

    // Random stepping (R5, R7-R10)
    for (int k = 0; k < 6; k++) begin
      do_load(8'($urandom()));
      for (int j = 0; j < 60; j++) do_step(8'($urandom()), "R5 random step");
    end

    // R6 free run with constant condition; R3 drop while running; R5 step while running
    cond_in = 8'($urandom());
    host_start = 1'b1;
    @(negedge clk);
    host_start = 1'b0;
    chk(running == 1, "R6 start", running, 1);
    chk_state("R6 no advance at start");
    for (int j = 0; j < 40; j++) begin
      if (j == 10) host_step = 1'b1;
      @(negedge clk);
      host_step = 1'b0;
      model_adv(cond_in);
      chk_state("R6 run");
    end
    a = ref_pc + 8'd7;
    host_wr_en = 1'b1; host_wr_addr = 8'h10; host_wr_data = 16'hFFFF;
    host_pc_ld = 1'b1; host_pc_val = a;
    @(negedge clk);
    host_wr_en = 1'b0; host_pc_ld = 1'b0;
    model_adv(cond_in);
    chk(host_err == 1, "R3 err pulse", host_err, 1);
    chk_state("R3 preload ignored");
    @(negedge clk);
    model_adv(cond_in);
    chk(host_err == 0, "R3 err one cycle", host_err, 0);
    host_halt = 1'b1; host_start = 1'b1;
    @(negedge clk);
    host_halt = 1'b0; host_start = 1'b0;
    chk(running == 0, "R6 halt wins", running, 0);
    chk_state("R6 no advance at halt");
    repeat (2) @(negedge clk);
    chk_state("R6 stays halted");
    do_load(8'h10);
    do_step(8'h00, "R3 store untouched");
    chk(pipe_word == 16'h0A55, "R3 word kept", pipe_word, 16'h0A55);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule